// File: doc/BRIEF.md
# Trigger Line Switch Matrix

This block routes trigger pulses between a module's backplane trigger lines and the trigger ports of the plug-in cards it carries. There are three kinds of source: a group of differential-class backplane lines, a group of single-ended backplane lines, and one trigger output per card. There are two kinds of destination: one trigger input per card and the single-ended backplane lines. Each destination owns an enable mask with one bit per source. A destination is the logical OR of every source whose bit is set, so one source can reach many destinations and many sources can merge into one.

Masks are written one destination at a time through a small write port and can be read back combinationally. Bits that would form an illegal route are cleared as they are written. A card output never loops back to its own input, and a single-ended backplane line accepts only card outputs. A single-ended line drives the backplane only while its mask is non-zero; at all other times it stays an input. A parameter inserts an output register stage after the OR network, and the drive enables pass through that same stage.

Top module: `trig_mx_top`

## Requirements
- R1: While reset is asserted and on the first clock after it, every mask reads zero and every card input, single-ended output and drive enable is low.
- R2: Mask bit layout (defaults 4 differential, 6 single-ended, 8 cards): bits [3:0] select differential lines 0-3, bits [9:4] single-ended lines 0-5, bits [17:10] card outputs 0-7. Addresses 0-7 select card inputs 0-7 and addresses 8-13 select single-ended lines 0-5. `cfg_rdata` shows the stored mask of the destination at `cfg_addr`.
- R3: A mask written with `cfg_we` high is stored at that clock edge and is visible on `cfg_rdata` right after it. The routed output reflects the new mask one clock later.
- R4: A single source enabled in several masks drives all those destinations at once.
- R5: A destination output is the OR of its enabled sources. With no enabled source active it is low.
- R6: Bit 10+k of the mask for card input k is always stored as zero, so card k is never routed to itself.
- R7: A single-ended destination stores only card bits [17:10]. Its bits [9:0] always read zero.
- R8: The drive enable of single-ended line j is high exactly when its stored mask is non-zero, delayed through the output stage. While the enable is low, its output is low.
- R9: A write to an address of 14 or above changes no mask and no output.
- R10: A write to one destination leaves the mask and output of every other destination unchanged.
- R11: With the output stage present (default), a source change reaches the destination outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_addr | input | 4 | Destination index for write and readback |
| cfg_wdata | input | 18 | Mask value to write |
| cfg_rdata | output | 18 | Stored mask of the addressed destination |
| diff_in | input | 4 | Differential-class backplane trigger lines (after level translation) |
| se_in | input | 6 | Single-ended backplane lines as sensed |
| card_src | input | 8 | Trigger outputs of the cards |
| card_dst | output | 8 | Trigger inputs of the cards |
| se_out | output | 6 | Value driven onto the single-ended lines |
| se_oe | output | 6 | Drive enable per single-ended line |

## Verification
The checker assumes that the sources are synchronous to `clk`, since it compares each output with the sources and masks one edge earlier. It also assumes that `cfg_addr` and `cfg_we` are never unknown out of reset. The bench changes every input half a period away from the rising edge and holds it for at least one full cycle. It clears all masks before each table entry, so only the route under test can affect the outputs, and it never drives an unknown value.

// File: rtl/trig_mx_pkg.sv
package trig_mx_pkg;
   localparam int MAX_PORTS = 24;
   typedef logic [MAX_PORTS-1:0] wide_mask_t;

   // Legal source bits for a destination index.
   function automatic wide_mask_t legal_mask(input int dst, input int n_diff,
                                             input int n_se, input int n_card);
      wide_mask_t m;
      int base;
      m    = '0;
      base = n_diff + n_se;
      for (int i = 0; i < MAX_PORTS; i++) begin
         if (i < base)
            m[i] = (dst < n_card);
         else if (i < base + n_card)
            m[i] = (i != base + dst);
      end
      return m;
   endfunction

   function automatic int addr_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/trig_mx_cfg.sv
module trig_mx_cfg
   import trig_mx_pkg::*;
#(
   parameter int N_DIFF = 4,
   parameter int N_SE   = 6,
   parameter int N_CARD = 8,
   localparam int NSRC  = N_DIFF + N_SE + N_CARD,
   localparam int NDST  = N_CARD + N_SE,
   localparam int AW    = addr_bits(NDST)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_sel,
   input  logic [NSRC-1:0]      wr_val,
   output logic [NSRC-1:0]      rd_val,
   output logic [NDST*NSRC-1:0] masks
);
   logic [NSRC-1:0] mask_q [NDST];

   for (genvar d = 0; d < NDST; d++) begin : g_dst
      localparam wide_mask_t      LW    = legal_mask(d, N_DIFF, N_SE, N_CARD);
      localparam logic [NSRC-1:0] LEGAL = LW[NSRC-1:0];
      localparam logic [AW-1:0]   MY_ID = AW'(d);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[d] <= '0;
         else if (wr_en && (wr_sel == MY_ID))
            mask_q[d] <= wr_val & LEGAL;
      end

      assign masks[d*NSRC +: NSRC] = mask_q[d];
   end

   always_comb begin
      rd_val = '0;
      for (int d = 0; d < NDST; d++)
         if (int'(wr_sel) == d)
            rd_val = mask_q[d];
   end
endmodule

// File: rtl/trig_mx_route.sv
module trig_mx_route #(
   parameter int N_DIFF = 4,
   parameter int N_SE   = 6,
   parameter int N_CARD = 8,
   localparam int NSRC  = N_DIFF + N_SE + N_CARD,
   localparam int NDST  = N_CARD + N_SE
) (
   input  logic [NSRC-1:0]      src,
   input  logic [NDST*NSRC-1:0] masks,
   output logic [NDST-1:0]      hit,
   output logic [N_SE-1:0]      drive_req
);
   for (genvar d = 0; d < NDST; d++) begin : g_or
      assign hit[d] = |(masks[d*NSRC +: NSRC] & src);
   end

   for (genvar j = 0; j < N_SE; j++) begin : g_drv
      assign drive_req[j] = |masks[(N_CARD+j)*NSRC +: NSRC];
   end
endmodule

// File: rtl/trig_mx_stage.sv
module trig_mx_stage #(
   parameter int W       = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_wire
      assign q = d;
   end
endmodule

// File: rtl/trig_mx_top.sv
module trig_mx_top
   import trig_mx_pkg::*;
#(
   parameter int N_DIFF  = 4,
   parameter int N_SE    = 6,
   parameter int N_CARD  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int NSRC   = N_DIFF + N_SE + N_CARD,
   localparam int NDST   = N_CARD + N_SE,
   localparam int AW     = addr_bits(NDST)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [NSRC-1:0] cfg_wdata,
   output logic [NSRC-1:0] cfg_rdata,
   input  logic [N_DIFF-1:0] diff_in,
   input  logic [N_SE-1:0]   se_in,
   input  logic [N_CARD-1:0] card_src,
   output logic [N_CARD-1:0] card_dst,
   output logic [N_SE-1:0]   se_out,
   output logic [N_SE-1:0]   se_oe
);
   if (N_DIFF < 1 || N_DIFF > MAX_PORTS) begin : g_bad_diff
      $error("trig_mx_top: N_DIFF out of range");
   end
   if (N_SE < 1 || N_SE > MAX_PORTS) begin : g_bad_se
      $error("trig_mx_top: N_SE out of range");
   end
   if (N_CARD < 1 || N_CARD > MAX_PORTS) begin : g_bad_card
      $error("trig_mx_top: N_CARD out of range");
   end
   if (NSRC > MAX_PORTS || NDST > MAX_PORTS) begin : g_bad_total
      $error("trig_mx_top: matrix side wider than mask limit");
   end

   localparam int SW = NDST + N_SE;

   logic [NDST*NSRC-1:0] mask_flat;
   logic [NSRC-1:0]      src_vec;
   logic [NDST-1:0]      hit;
   logic [N_SE-1:0]      drive_req;
   logic [SW-1:0]        stage_q;

   assign src_vec = {card_src, se_in, diff_in};

   trig_mx_cfg #(.N_DIFF(N_DIFF), .N_SE(N_SE), .N_CARD(N_CARD)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_we),
      .wr_sel(cfg_addr),
      .wr_val(cfg_wdata),
      .rd_val(cfg_rdata),
      .masks (mask_flat)
   );

   trig_mx_route #(.N_DIFF(N_DIFF), .N_SE(N_SE), .N_CARD(N_CARD)) u_route (
      .src      (src_vec),
      .masks    (mask_flat),
      .hit      (hit),
      .drive_req(drive_req)
   );

   trig_mx_stage #(.W(SW), .OUT_REG(OUT_REG)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({drive_req, hit}),
      .q    (stage_q)
   );

   assign card_dst = stage_q[N_CARD-1:0];
   assign se_out   = stage_q[NDST-1:N_CARD];
   assign se_oe    = stage_q[SW-1:NDST];
endmodule

// File: rtl/trig_mx_chk.sv
module trig_mx_chk
   import trig_mx_pkg::*;
#(
   parameter int N_DIFF  = 4,
   parameter int N_SE    = 6,
   parameter int N_CARD  = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int NSRC   = N_DIFF + N_SE + N_CARD,
   localparam int NDST   = N_CARD + N_SE,
   localparam int AW     = addr_bits(NDST),
   localparam int CB     = N_DIFF + N_SE
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [AW-1:0]        cfg_addr,
   input logic [N_DIFF-1:0]    diff_in,
   input logic [N_SE-1:0]      se_in,
   input logic [N_CARD-1:0]    card_src,
   input logic [N_CARD-1:0]    card_dst,
   input logic [N_SE-1:0]      se_out,
   input logic [N_SE-1:0]      se_oe,
   input logic [NDST*NSRC-1:0] mask_flat
);
   logic [NSRC-1:0] src;
   assign src = {card_src, se_in, diff_in};

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_flat == '0 && card_dst == '0 && se_oe == '0 && se_out == '0));

   assert_oe_gates_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (se_out & ~se_oe) == '0);

   if ((1 << AW) > NDST) begin : g_oob
      assert_oob_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && int'(cfg_addr) >= NDST) |=> $stable(mask_flat));
   end

   for (genvar d = 0; d < NDST; d++) begin : g_d
      localparam logic [AW-1:0] MY_ID = AW'(d);
      assert_other_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !(cfg_we && cfg_addr == MY_ID) |=> $stable(mask_flat[d*NSRC +: NSRC]));
   end

   for (genvar k = 0; k < N_CARD; k++) begin : g_card
      localparam logic [AW-1:0] MY_ID = AW'(k);
      assert_no_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == MY_ID) |=> !mask_flat[k*NSRC + CB + k]);
      if (OUT_REG) begin : g_r
         // R11: one-edge latency through the output stage
         assert_fanin_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
            card_dst[k] == $past(|(mask_flat[k*NSRC +: NSRC] & src)));
      end else begin : g_c
         assert_fanin_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
            card_dst[k] == |(mask_flat[k*NSRC +: NSRC] & src));
      end
   end

   for (genvar j = 0; j < N_SE; j++) begin : g_se
      localparam int D = N_CARD + j;
      localparam logic [AW-1:0] MY_ID = AW'(D);
      assert_se_card_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == MY_ID) |=> (mask_flat[D*NSRC +: CB] == '0));
      if (OUT_REG) begin : g_r
         assert_se_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
            se_out[j] == $past(|(mask_flat[D*NSRC +: NSRC] & src)));
         assert_drive_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            se_oe[j] == $past(|mask_flat[D*NSRC +: NSRC]));
      end else begin : g_c
         assert_se_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
            se_out[j] == |(mask_flat[D*NSRC +: NSRC] & src));
         assert_drive_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            se_oe[j] == |mask_flat[D*NSRC +: NSRC]);
      end
   end
endmodule

bind trig_mx_top trig_mx_chk #(
   .N_DIFF(N_DIFF), .N_SE(N_SE), .N_CARD(N_CARD), .OUT_REG(OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .diff_in  (diff_in),
   .se_in    (se_in),
   .card_src (card_src),
   .card_dst (card_dst),
   .se_out   (se_out),
   .se_oe    (se_oe),
   .mask_flat(mask_flat)
);

// File: tb/sim_trig_mx_top.sv
`timescale 1ns/1ps
module sim_trig_mx_top;
   localparam int ND = 4, NS = 6, NC = 8;
   localparam int NSRC = ND + NS + NC;   // 18
   localparam int NDST = NC + NS;        // 14

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_we;
   logic [3:0]      cfg_addr;
   logic [NSRC-1:0] cfg_wdata;
   logic [NSRC-1:0] cfg_rdata;
   logic [ND-1:0]   diff_in;
   logic [NS-1:0]   se_in;
   logic [NC-1:0]   card_src;
   logic [NC-1:0]   card_dst;
   logic [NS-1:0]   se_out;
   logic [NS-1:0]   se_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   trig_mx_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .diff_in(diff_in),
      .se_in(se_in), .card_src(card_src), .card_dst(card_dst),
      .se_out(se_out), .se_oe(se_oe)
   );

   typedef struct packed {
      logic [3:0]  a;
      logic [17:0] w;
      logic [3:0]  dv;
      logic [5:0]  sv;
      logic [7:0]  cv;
      logic [17:0] er;
      logic        eo;
   } vec_t;

   localparam vec_t TBL [10] = '{
      '{4'd0,  18'h00001, 4'b0001, 6'h00, 8'h00, 18'h00001, 1'b1}, // R2 diff0 -> card0
      '{4'd0,  18'h00001, 4'b0000, 6'h00, 8'h00, 18'h00001, 1'b0}, // R5 source idle
      '{4'd3,  18'h00020, 4'b0000, 6'h02, 8'h00, 18'h00020, 1'b1}, // R2 se1 -> card3
      '{4'd3,  18'h02000, 4'b0000, 6'h00, 8'h08, 18'h00000, 1'b0}, // R6 self bit dropped
      '{4'd3,  18'h08000, 4'b0000, 6'h00, 8'h20, 18'h08000, 1'b1}, // R2 card5 -> card3
      '{4'd9,  18'h3FFFF, 4'b1111, 6'h3F, 8'h00, 18'h3FC00, 1'b0}, // R7 only card bits kept
      '{4'd9,  18'h00400, 4'b0000, 6'h00, 8'h01, 18'h00400, 1'b1}, // R7 card0 -> se1
      '{4'd7,  18'h0000F, 4'b0100, 6'h00, 8'h00, 18'h0000F, 1'b1}, // R5 OR of diff lines
      '{4'd7,  18'h0000F, 4'b0000, 6'h00, 8'h00, 18'h0000F, 1'b0}, // R5 none active
      '{4'd13, 18'h20000, 4'b0000, 6'h00, 8'h80, 18'h20000, 1'b1}  // R8 card7 -> se5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [NSRC-1:0] d);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = 4'(a);
      cfg_wdata = d;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic clear_all();
      for (int d = 0; d < NDST; d++) wr(d, '0);
   endtask

   task automatic idle_src();
      diff_in = '0; se_in = '0; card_src = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R11 act=timeout exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      diff_in = '1; se_in = '1; card_src = '1;
      repeat (3) @(negedge clk);
      // R1: outputs low in reset even with all sources high
      check("R1 card_dst in reset", 32'(card_dst), 32'h0);
      check("R1 se_oe in reset", 32'(se_oe), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 card_dst after reset", 32'(card_dst), 32'h0);
      check("R1 se_out after reset", 32'(se_out), 32'h0);
      for (int d = 0; d < NDST; d++) begin
         cfg_addr = 4'(d);
         #0.1;
         check("R1 mask zero after reset", 32'(cfg_rdata), 32'h0);
      end
      idle_src();

      // Table walk
      for (int i = 0; i < 10; i++) begin
         logic [NC-1:0] e_card;
         logic [NS-1:0] e_se, e_oe;
         clear_all();
         wr(int'(TBL[i].a), TBL[i].w);
         check("R2 table readback", 32'(cfg_rdata), 32'(TBL[i].er));
         diff_in = TBL[i].dv; se_in = TBL[i].sv; card_src = TBL[i].cv;
         e_card = '0; e_se = '0; e_oe = '0;
         if (TBL[i].a < NC) e_card[TBL[i].a] = TBL[i].eo;
         else begin
            e_se[TBL[i].a - NC] = TBL[i].eo;
            e_oe[TBL[i].a - NC] = (TBL[i].er != '0);
         end
         @(negedge clk);
         check("R5 table card_dst", 32'(card_dst), 32'(e_card));
         check("R5 table se_out", 32'(se_out), 32'(e_se));
         check("R8 table se_oe", 32'(se_oe), 32'(e_oe));
         idle_src();
      end

      // R9: out-of-range writes ignored
      clear_all();
      wr(14, '1);
      wr(15, '1);
      diff_in = '1; se_in = '1; card_src = '1;
      for (int d = 0; d < NDST; d++) begin
         cfg_addr = 4'(d);
         #0.1;
         check("R9 mask untouched", 32'(cfg_rdata), 32'h0);
      end
      @(negedge clk);
      check("R9 card_dst quiet", 32'(card_dst), 32'h0);
      check("R8 se_out low with oe low", 32'(se_out), 32'h0);
      check("R8 se_oe low", 32'(se_oe), 32'h0);
      idle_src();

      // R4: card4 fans out to card1, card2 and se0
      wr(1, 18'h04000); wr(2, 18'h04000); wr(8, 18'h04000);
      card_src = 8'h10;
      @(negedge clk);
      check("R4 fan-out card_dst", 32'(card_dst), 32'h06);
      check("R4 fan-out se_out", 32'(se_out), 32'h01);
      check("R4 fan-out se_oe", 32'(se_oe), 32'h01);

      // R10: writes to card2 do not disturb card1
      for (int k = 0; k < 4; k++) begin
         wr(2, 18'(k));
         check("R10 card1 steady", 32'(card_dst[1]), 32'h1);
      end
      cfg_addr = 4'd1;
      #0.1;
      check("R10 card1 mask kept", 32'(cfg_rdata), 32'h04000);
      idle_src();
      clear_all();

      // R3 and R11: write timing and source latency
      diff_in = 4'b0001;
      wr(0, 18'h00001);
      check("R3 readback right after write", 32'(cfg_rdata), 32'h00001);
      check("R3 output not yet updated", 32'(card_dst[0]), 32'h0);
      @(negedge clk);
      check("R3 output one edge later", 32'(card_dst[0]), 32'h1);
      diff_in = 4'b0000;
      #0.1;
      check("R11 output holds before edge", 32'(card_dst[0]), 32'h1);
      @(negedge clk);
      check("R11 output after one edge", 32'(card_dst[0]), 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule